// File: doc/BRIEF.md
# Dock Data Latch Literal Loader

This block holds a dock's 37-bit data word and loads it under a small command interface. An instruction that carries a literal is first *presented*: its load kind, its 19-bit immediate and its sign bit are copied into a pending register. Later, an *execute* strobe applies that pending literal to the latch. The literal can be applied in one of two ways. A shift load moves the old low bits up and puts the immediate underneath them, so that wide constants can be built 19 bits at a time. An extend load places a 14-bit immediate at the bottom of the latch and fills every bit above it with the sign bit.

A separate capture strobe copies a whole incoming data word into the latch. The upper 11 bits of the latch form the path field. These bits are driven out on their own port for moves that dispatch along a path held in the data word.

Top module: `dock_literal_latch`

## Requirements
- R1: After reset, `latch_q` and `path_q` are zero. The pending register also resets to the hold kind, so an execute strobe with nothing presented leaves the latch at zero.
- R2: When the pending kind is shift (`kind` 2'b01), an execute strobe loads the latch with `{old latch[17:0], immediate[18:0]}`. The result is visible one clock after the strobe.
- R3: When the pending kind is extend (`kind` 2'b10), an execute strobe loads immediate bits [13:0] into latch bits [13:0]. The pending sign bit is written to latch bits [36:14], and immediate bits [18:14] are ignored.
- R4: The pending register takes kind, immediate and sign only on a cycle in which `ondeck_valid` is high, and keeps them until the next presentation. Execution uses the value captured earlier, so a later change on `ondeck_imm` has no effect. A presentation in the same cycle as an execute affects only later executes.
- R5: When `capture` is high and no literal load executes in that cycle, the latch loads `cap_word`.
- R6: When an execute of a shift or extend load and `capture` occur in the same cycle, the literal load wins and `cap_word` is ignored.
- R7: When the pending kind is hold (`kind` 2'b00 or 2'b11), an execute strobe leaves the latch unchanged. A capture in the same cycle still loads `cap_word`.
- R8: `path_q` always equals latch bits [36:26].
- R9: With neither `exec` nor `capture` high, the latch keeps its value, even while instructions are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ondeck_valid | input | 1 | Presents an instruction; captures kind, immediate, sign |
| ondeck_kind | input | 2 | Load kind: 00 hold, 01 shift, 10 extend, 11 hold |
| ondeck_imm | input | 19 | Immediate of the presented instruction |
| ondeck_sign | input | 1 | Sign bit for the extend load |
| exec | input | 1 | Executes the pending instruction |
| capture | input | 1 | Loads the incoming data word |
| cap_word | input | 37 | Incoming data word |
| latch_q | output | 37 | Current latch contents |
| path_q | output | 11 | Upper path field of the latch |

## Verification
Every latch update is due exactly one clock after the strobe that causes it. A presentation also needs one clock before its literal can be used by an execute. `path_q` follows the latch with no further delay, because it is a slice of the latch. The bench drives strobes on the falling edge for one cycle and reads `latch_q` and `path_q` on the next falling edge. That is half a period after the single register update, and no other sample point is used. For the hold and idle cases, the bench waits several more cycles and checks again to confirm that nothing moved.

// File: rtl/dock_literal_latch.sv
module dock_literal_latch #(
  parameter int WORD_W  = 37,
  parameter int PATH_W  = 11,
  parameter int SHIFT_W = 19,
  parameter int SEXT_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ondeck_valid,
  input  logic [1:0]        ondeck_kind,
  input  logic [SHIFT_W-1:0] ondeck_imm,
  input  logic              ondeck_sign,
  input  logic              exec,
  input  logic              capture,
  input  logic [WORD_W-1:0] cap_word,
  output logic [WORD_W-1:0] latch_q,
  output logic [PATH_W-1:0] path_q
);
  localparam int KEEP_W = WORD_W - SHIFT_W;
  localparam int EXT_W  = WORD_W - SEXT_W;
  localparam logic [1:0] K_SHIFT = 2'b01;
  localparam logic [1:0] K_SEXT  = 2'b10;

  logic [1:0]         pend_kind;
  logic [SHIFT_W-1:0] pend_imm;
  logic               pend_sign;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_kind <= '0;
      pend_imm  <= '0;
      pend_sign <= 1'b0;
    end else if (ondeck_valid) begin
      pend_kind <= ondeck_kind;
      pend_imm  <= ondeck_imm;
      pend_sign <= ondeck_sign;
    end
  end

  wire do_shift = exec && (pend_kind == K_SHIFT);
  wire do_sext  = exec && (pend_kind == K_SEXT);

  wire [WORD_W-1:0] shift_val = {latch_q[KEEP_W-1:0], pend_imm};
  wire [WORD_W-1:0] sext_val  = {{EXT_W{pend_sign}}, pend_imm[SEXT_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (do_shift) latch_q <= shift_val;
    else if (do_sext)  latch_q <= sext_val;
    else if (capture)  latch_q <= cap_word;
  end

  assign path_q = latch_q[WORD_W-1 -: PATH_W];
endmodule

// File: rtl/dock_literal_latch_checker.sv
module dock_literal_latch_checker #(
  parameter int WORD_W  = 37,
  parameter int SHIFT_W = 19,
  parameter int SEXT_W  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ondeck_valid,
  input logic              exec,
  input logic              capture,
  input logic [WORD_W-1:0] cap_word,
  input logic [WORD_W-1:0] latch_q,
  input logic [1:0]        pend_kind,
  input logic [SHIFT_W-1:0] pend_imm,
  input logic              pend_sign
);
  localparam int KEEP_W = WORD_W - SHIFT_W;
  localparam int EXT_W  = WORD_W - SEXT_W;

  assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && pend_kind == 2'b01) |=>
      latch_q == {$past(latch_q[KEEP_W-1:0]), $past(pend_imm)});

  assert_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && pend_kind == 2'b10) |=>
      latch_q == {{EXT_W{$past(pend_sign)}}, $past(pend_imm[SEXT_W-1:0])});

  assert_pending_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ondeck_valid |=> $stable(pend_imm) && $stable(pend_kind) && $stable(pend_sign));

  assert_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !(exec && (pend_kind == 2'b01 || pend_kind == 2'b10))) |=>
      latch_q == $past(cap_word));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !capture && (pend_kind == 2'b00 || pend_kind == 2'b11)) |=> $stable(latch_q));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec && !capture) |=> $stable(latch_q));
endmodule

bind dock_literal_latch dock_literal_latch_checker #(
  .WORD_W(WORD_W), .SHIFT_W(SHIFT_W), .SEXT_W(SEXT_W)
) chk (
  .clk(clk), .rst_n(rst_n), .ondeck_valid(ondeck_valid), .exec(exec),
  .capture(capture), .cap_word(cap_word), .latch_q(latch_q),
  .pend_kind(pend_kind), .pend_imm(pend_imm), .pend_sign(pend_sign)
);

// File: tb/dock_literal_latch_test.sv
module dock_literal_latch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ondeck_valid = 1'b0;
  logic [1:0]  ondeck_kind = 2'b00;
  logic [18:0] ondeck_imm = '0;
  logic        ondeck_sign = 1'b0;
  logic        exec = 1'b0;
  logic        capture = 1'b0;
  logic [36:0] cap_word = '0;
  logic [36:0] latch_q;
  logic [10:0] path_q;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [36:0] exp;

  always #10 clk = ~clk;

  dock_literal_latch uut (
    .clk(clk), .rst_n(rst_n), .ondeck_valid(ondeck_valid), .ondeck_kind(ondeck_kind),
    .ondeck_imm(ondeck_imm), .ondeck_sign(ondeck_sign), .exec(exec),
    .capture(capture), .cap_word(cap_word), .latch_q(latch_q), .path_q(path_q)
  );

  task automatic check(string req, logic [36:0] act, logic [36:0] want);
    tests++;
    if (act !== want) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, want);
    end
  endtask

  task automatic check_latch(string req);
    check(req, latch_q, exp);
    check("R8", {26'b0, path_q}, {26'b0, exp[36:26]});
  endtask

  task automatic present(logic [1:0] k, logic [18:0] imm, logic s);
    ondeck_valid = 1'b1; ondeck_kind = k; ondeck_imm = imm; ondeck_sign = s;
    @(negedge clk);
    ondeck_valid = 1'b0; ondeck_imm = ~imm; ondeck_sign = ~s; ondeck_kind = ~k;
  endtask

  task automatic execute(logic cap, logic [36:0] w);
    exec = 1'b1; capture = cap; cap_word = w;
    @(negedge clk);
    exec = 1'b0; capture = 1'b0; cap_word = ~w;
  endtask

  task automatic capture_only(logic [36:0] w);
    capture = 1'b1; cap_word = w;
    @(negedge clk);
    capture = 1'b0; cap_word = ~w;
  endtask

  task automatic t_reset;
    exp = '0;
    check_latch("R1");
    execute(1'b0, '0);
    check_latch("R1");
  endtask

  task automatic t_shift;
    present(2'b01, 19'h5A5A5, 1'b0);
    execute(1'b0, '0);
    exp = {18'b0, 19'h5A5A5};
    check_latch("R2");
    present(2'b01, 19'h7FFFF, 1'b0);
    execute(1'b0, '0);
    exp = {exp[17:0], 19'h7FFFF};
    check_latch("R2");
    execute(1'b0, '0);
    exp = {exp[17:0], 19'h7FFFF};
    check_latch("R4");
  endtask

  task automatic t_sext;
    present(2'b10, 19'h01234, 1'b1);
    execute(1'b0, '0);
    exp = {23'h7FFFFF, 14'h1234};
    check_latch("R3");
    present(2'b10, 19'h7D234, 1'b0);
    execute(1'b0, '0);
    exp = {23'h0, 14'h1234};
    check_latch("R3");
  endtask

  task automatic t_overlap;
    present(2'b01, 19'h00003, 1'b0);
    ondeck_valid = 1'b1; ondeck_kind = 2'b10; ondeck_imm = 19'h00005; ondeck_sign = 1'b1;
    exec = 1'b1;
    @(negedge clk);
    ondeck_valid = 1'b0; exec = 1'b0; ondeck_imm = '0; ondeck_kind = 2'b00;
    exp = {exp[17:0], 19'h00003};
    check_latch("R4");
    execute(1'b0, '0);
    exp = {23'h7FFFFF, 14'h0005};
    check_latch("R4");
  endtask

  task automatic t_capture;
    capture_only(37'h1_2345_6789);
    exp = 37'h1_2345_6789;
    check_latch("R5");
    capture_only(37'h1F_FFFF_FFFF);
    exp = 37'h1F_FFFF_FFFF;
    check_latch("R5");
  endtask

  task automatic t_priority;
    present(2'b01, 19'h00ABC, 1'b0);
    execute(1'b1, 37'h0A_AAAA_AAAA);
    exp = {exp[17:0], 19'h00ABC};
    check_latch("R6");
    present(2'b10, 19'h00001, 1'b0);
    execute(1'b1, 37'h15_5555_5555);
    exp = 37'h1;
    check_latch("R6");
  endtask

  task automatic t_hold;
    capture_only(37'h0C_0FFE_E123);
    exp = 37'h0C_0FFE_E123;
    present(2'b00, 19'h7FFFF, 1'b1);
    execute(1'b0, '0);
    check_latch("R7");
    present(2'b11, 19'h12345, 1'b1);
    execute(1'b0, '0);
    check_latch("R7");
    execute(1'b1, 37'h03_1415_9265);
    exp = 37'h03_1415_9265;
    check_latch("R7");
  endtask

  task automatic t_idle;
    present(2'b01, 19'h11111, 1'b0);
    present(2'b10, 19'h22222, 1'b1);
    repeat (3) @(negedge clk);
    check_latch("R9");
    execute(1'b0, '0);
    exp = {23'h7FFFFF, 14'h2222};
    check_latch("R4");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shift();
    t_sext();
    t_overlap();
    t_capture();
    t_priority();
    t_hold();
    t_idle();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule